// File: doc/BRIEF.md
# Banked ROM/RAM Address Decoder

This block turns a 16-bit CPU address, a read/write line and the bus enable phase E into three active-low chip selects: one for RAM, one for ROM and one for the I/O page. Two ROM banks sit in the top quarter of the map. The lower bank covers $C000-$DFFF. The upper bank covers $E200-$FFFF. Between them is a 512-byte I/O page at $E000-$E1FF.

A small control register lives at the last byte of the I/O page, $E1FF. Each of its low bits removes one ROM bank from the read path, so that RAM answers at those addresses instead. Writes that land in either ROM window are always sent to the RAM underneath, whether or not that bank is enabled. Software can therefore shadow ROM into RAM in place: it reads each byte and writes it back to the same address, then switches the bank out.

The region decode is written as hand-minimized equations on the upper address bits, not as range comparators.

Top module: `shadow_map_decoder`

## Requirements
- R1: While rst_ni is low, and after reset, the control register holds 0. Both banks are then enabled and readback_o reads 0.
- R2: When e_i is low, ram_cs_no, rom_cs_no and io_cs_no are all high.
- R3: With e_i high, any address from $0000 to $BFFF asserts only ram_cs_no, for reads and for writes.
- R4: With e_i high, any address from $E000 to $E1FF asserts only io_cs_no, for reads and for writes. This includes the control register at $E1FF.
- R5: A read (rw_i=1, e_i high) in $C000-$DFFF while control bit 0 is 0 asserts only rom_cs_no.
- R6: A read (rw_i=1, e_i high) in $E200-$FFFF while control bit 1 is 0 asserts only rom_cs_no.
- R7: A write (rw_i=0, e_i high) anywhere in $C000-$DFFF or $E200-$FFFF asserts only ram_cs_no, for every control register value.
- R8: Control bit 0 set makes reads in $C000-$DFFF select RAM. Control bit 1 set makes reads in $E200-$FFFF select RAM. Each bit affects only its own bank.
- R9: A write with e_i high to $E1FF loads data_i[1:0] into the control register on that rising clock edge. readback_o then shows the register in bits 1:0 and zeros in bits 7:2.
- R10: Reads of $E1FF, writes to any other address and cycles with e_i low leave the control register unchanged.
- R11: With e_i high, exactly one of the three selects is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the control register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | CPU address |
| rw_i | input | 1 | 1 = read, 0 = write |
| e_i | input | 1 | Bus enable phase; qualifies all selects and the register write |
| data_i | input | 8 | CPU write data; bits 1:0 feed the control register |
| ram_cs_no | output | 1 | Active-low RAM select |
| rom_cs_no | output | 1 | Active-low ROM select |
| io_cs_no | output | 1 | Active-low I/O page select |
| readback_o | output | 8 | Control register value, zero-extended |

## Verification
Two functions can meet on adjacent bus cycles: an overlay change through the control register, and a ROM-window access that depends on the new setting. In the same way, a write-through into a bank can meet a read of that same byte. The bench provokes this with directed back-to-back sequences. A register write flips one bank and is followed at once by a read and a write in that bank and in the other bank. Random traffic is weighted towards $E1FF and the top quarter of the map. Each select is judged in the cycle of the access against a bench model that tracks the register it expects, so a one-cycle lag in the overlay or a write that leaks to ROM shows up as a mismatch.

// File: rtl/shadow_map_pkg.sv
package shadow_map_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned NUM_BANKS = 2;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 16'hE1FF;

  typedef struct packed {
    logic ram;
    logic rom;
    logic io;
  } sel_t;
endpackage

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_map_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 io_page_o,
  output logic [NUM_BANKS-1:0] bank_hit_o
);
  logic top_q;  // $C000-$FFFF
  logic hi_8k;  // $E000-$FFFF

  assign top_q     = addr_i[15] & addr_i[14];
  assign hi_8k     = top_q & addr_i[13];
  // I/O hole: A12..A9 all zero inside the upper 8K
  assign io_page_o = hi_8k & ~(|addr_i[12:9]);

  assign bank_hit_o[0] = top_q & ~addr_i[13];
  assign bank_hit_o[1] = hi_8k & (|addr_i[12:9]);
endmodule

// File: rtl/shadow_bank_ctl.sv
module shadow_bank_ctl #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/shadow_map_decoder.sv
module shadow_map_decoder
  import shadow_map_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              rw_i,
  input  logic              e_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ram_cs_no,
  output logic              rom_cs_no,
  output logic              io_cs_no,
  output logic [DATA_W-1:0] readback_o
);
  logic                 io_page;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] bank_off;
  logic [NUM_BANKS-1:0] rom_live;
  logic                 ctl_wr;
  sel_t                 sel;

  shadow_region_decode u_dec (
    .addr_i     (addr_i),
    .io_page_o  (io_page),
    .bank_hit_o (bank_hit)
  );

  assign ctl_wr = e_i & ~rw_i & (addr_i == CTL_ADDR);

  shadow_bank_ctl #(.WIDTH(NUM_BANKS)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (ctl_wr),
    .wdata_i (data_i[NUM_BANKS-1:0]),
    .q_o     (bank_off)
  );

  // Per-bank overlay: ROM answers only for reads of an enabled bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign rom_live[b] = bank_hit[b] & ~bank_off[b];
  end

  always_comb begin
    sel     = '0;
    sel.io  = e_i & io_page;
    sel.rom = e_i & rw_i & (|rom_live);
    sel.ram = e_i & ~sel.io & ~sel.rom;
  end

  assign ram_cs_no  = ~sel.ram;
  assign rom_cs_no  = ~sel.rom;
  assign io_cs_no   = ~sel.io;
  assign readback_o = {{(DATA_W-NUM_BANKS){1'b0}}, bank_off};
endmodule

// File: rtl/shadow_map_checker.sv
module shadow_map_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       addr_i,
  input logic              rw_i,
  input logic              e_i,
  input logic [DATA_W-1:0] data_i,
  input logic              ram_cs_no,
  input logic              rom_cs_no,
  input logic              io_cs_no,
  input logic [DATA_W-1:0] readback_o
);
  logic reg_wr;
  logic rom_space;
  assign reg_wr    = e_i && !rw_i && (addr_i == 16'hE1FF);
  assign rom_space = (addr_i >= 16'hC000) && !(addr_i >= 16'hE000 && addr_i <= 16'hE1FF);

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> readback_o == '0);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e_i |-> (ram_cs_no && rom_cs_no && io_cs_no));
  a_r3_low_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_i && addr_i < 16'hC000) |-> !ram_cs_no);
  a_r4_io_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_i && addr_i >= 16'hE000 && addr_i <= 16'hE1FF) |-> (!io_cs_no && ram_cs_no));
  a_r7_write_thru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_i && !rw_i && rom_space) |-> (!ram_cs_no && rom_cs_no));
  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr |=> readback_o == {{(DATA_W-2){1'b0}}, $past(data_i[1:0])});
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr |=> $stable(readback_o));
  a_r11_one_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_i |-> $countones({ram_cs_no, rom_cs_no, io_cs_no}) == 2);
endmodule

bind shadow_map_decoder shadow_map_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rw_i(rw_i), .e_i(e_i),
  .data_i(data_i), .ram_cs_no(ram_cs_no), .rom_cs_no(rom_cs_no),
  .io_cs_no(io_cs_no), .readback_o(readback_o)
);

// File: tb/sim_shadow_map_decoder.sv
module sim_shadow_map_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rw_i = 1'b1;
  logic        e_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        ram_cs_no, rom_cs_no, io_cs_no;
  logic [7:0]  readback_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  logic [1:0] ref_ctl = 2'b00;

  always #10 clk_i = ~clk_i;

  shadow_map_decoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rw_i(rw_i), .e_i(e_i),
    .data_i(data_i), .ram_cs_no(ram_cs_no), .rom_cs_no(rom_cs_no),
    .io_cs_no(io_cs_no), .readback_o(readback_o)
  );

  // {ram_n, rom_n, io_n}
  function automatic logic [2:0] exp_cs(logic [15:0] a, logic rw, logic e, logic [1:0] ctl);
    if (!e)                                  return 3'b111;
    if (a >= 16'hE000 && a <= 16'hE1FF)      return 3'b110;
    if (rw && a >= 16'hC000 && a <= 16'hDFFF && !ctl[0]) return 3'b101;
    if (rw && a >= 16'hE200 && !ctl[1])      return 3'b101;
    return 3'b011;
  endfunction

  function automatic string req_of(logic [15:0] a, logic rw, logic e, logic [1:0] ctl);
    if (!e)                             return "R2";
    if (a < 16'hC000)                   return "R3";
    if (a <= 16'hE1FF && a >= 16'hE000) return "R4";
    if (!rw)                            return "R7";
    if (a < 16'hE000)                   return ctl[0] ? "R8" : "R5";
    return ctl[1] ? "R8" : "R6";
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (addr=%h rw=%b e=%b)", req, act, exp, addr_i, rw_i, e_i);
    end
  endtask

  // drive at negedge, check selects, commit at posedge, check readback
  task automatic cyc(logic [15:0] a, logic rw, logic e, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rw_i = rw; e_i = e; data_i = d;
    #2;
    chk(req_of(a, rw, e, ref_ctl), {13'd0, ram_cs_no, rom_cs_no, io_cs_no},
        {13'd0, exp_cs(a, rw, e, ref_ctl)});
    if (e) chk("R11", 16'(3 - ({1'b0,ram_cs_no} + rom_cs_no + io_cs_no)), 16'd1);
    @(posedge clk_i);
    if (e && !rw && a == 16'hE1FF) ref_ctl = d[1:0];
    #2;
    chk((e && !rw && a == 16'hE1FF) ? "R9" : "R10", {8'd0, readback_o}, {14'd0, ref_ctl});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [7];
    void'($urandom(32'h5EED_0042));
    edges = '{16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000, 16'hE1FF, 16'hE200, 16'hFFFF};
    #35;
    chk("R1", {8'd0, readback_o}, 16'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1", {8'd0, readback_o}, 16'd0);

    // boundaries under each control value, reads and writes
    for (int c = 0; c < 4; c++) begin
      cyc(16'hE1FF, 1'b0, 1'b1, 8'(c) | 8'hFC);  // upper bits ignored
      for (int i = 0; i < 7; i++) begin
        cyc(edges[i], 1'b1, 1'b1, 8'h00);
        if (edges[i] != 16'hE1FF) cyc(edges[i], 1'b0, 1'b1, 8'h00);
        cyc(edges[i], 1'b1, 1'b0, 8'h00);
      end
    end

    // overlay flip meeting write-through on adjacent cycles
    cyc(16'hE1FF, 1'b0, 1'b1, 8'h00);
    cyc(16'hC123, 1'b1, 1'b1, 8'h00);
    cyc(16'hC123, 1'b0, 1'b1, 8'h55);
    cyc(16'hE1FF, 1'b0, 1'b1, 8'h01);
    cyc(16'hC123, 1'b1, 1'b1, 8'h00);
    cyc(16'hF000, 1'b1, 1'b1, 8'h00);
    cyc(16'hE1FF, 1'b0, 1'b1, 8'h02);
    cyc(16'hC123, 1'b1, 1'b1, 8'h00);
    cyc(16'hF000, 1'b1, 1'b1, 8'h00);
    cyc(16'hF000, 1'b0, 1'b1, 8'h00);
    // register must not move on read, other I/O write, or E low
    cyc(16'hE1FF, 1'b1, 1'b1, 8'h00);
    cyc(16'hE1FE, 1'b0, 1'b1, 8'h01);
    cyc(16'hE1FF, 1'b0, 1'b0, 8'h01);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom_range(0, 7);
      a = 16'($urandom);
      if (sel == 0) a = 16'hE1FF;
      else if (sel < 5) a[15:14] = 2'b11;
      cyc(a, 1'($urandom), ($urandom_range(0, 5) != 0), 8'($urandom));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule